// File: doc/BRIEF.md
# DDR2 Power-Up Command Sequencer

This block walks a DDR2 device through its power-up procedure by replaying a table of host-loaded steps. Each of the twelve table slots holds two 32-bit words. The command word gives the raw levels for the clock-enable and the four command pins, plus the low byte of the row/column address. The timing word gives the high address byte, the bank and a wait count. Software fills the table and writes the issue register with a go bit and the index of the last slot to run. It then polls the go bit, which reads as busy until the last step's wait has fully expired.

For each slot the block drives one command cycle on the memory pins. It then holds a deselect/NOP for the programmed wait, with clock-enable kept at the level that command set. The wait count is meant to be computed as max(ceil(delay_ps / tCK_ps), 2) - 2. Because a step occupies exactly wait + 2 clocks, commands land ceil(delay / tCK) clocks apart. After the run, software writes the start register with 1 and then 3, which hands the memory to the normal traffic controller.

Top module: `ddr2_init_sequencer`

## Requirements
- R1: After reset CKE is low, CS#, RAS#, CAS# and WE# are high, BA and A are zero, the issue register reads 0 and `ctrl_release` is low.
- R2: A write to the issue register (word address 0x20) with bit 4 set and bits 3:0 = L (L < 12) runs slots 0 to L in order. The issue register reads bit 4 = busy and bits 3:0 = L.
- R3: In a slot's command cycle, CKE = command bit 12, CS# = bit 8, RAS# = bit 9, CAS# = bit 10 and WE# = bit 11. A[7:0] = command bits 31:24, A[15:8] = timing bits 7:0 and BA = timing bits 9:8.
- R4: Each command cycle is followed by W + 1 cycles of NOP, where W = timing bits 31:11. During NOP cycles CS#, RAS#, CAS# and WE# are high, BA and A are zero, and CKE keeps the level of the last command.
- R5: Busy rises on the clock that samples the go write and falls on the clock after the last slot's final NOP cycle, so a run lasts the sum of (W + 2) over the slots.
- R6: While busy, writes to the table and to the issue register are ignored.
- R7: An issue write whose index field is 12 or more is ignored entirely. An issue write with bit 4 clear only records the index.
- R8: Slot i's command word is at word address 0x00 + i and its timing word at 0x10 + i, both readable. Writes to slots 12 to 15 are dropped, and those slots read 0.
- R9: The start register (word address 0x21, bits 1:0) reads back as written, and `ctrl_release` is high only while both bits are set.
- R10: Between runs the pins show NOP, and CKE holds the level of the last executed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 6 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ddr_cke | output | 1 | Clock enable to the memory |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BA_W | Bank address |
| ddr_a | output | 16 | Address bus |
| ctrl_release | output | 1 | Memory handed to the traffic controller |

## Verification
The properties assume that a run begins only through an issue write with the go bit set, and that every register write is a single-cycle strobe with a stable address. Under those conditions a rise of busy always follows a go write, and the slot pointer never passes the recorded last index. The stimulus changes inputs only on the falling clock edge and holds each write for exactly one cycle. It deliberately places table and issue writes inside a busy window, as well as issue writes with an out-of-range index. This exercises the ignore paths without breaking any of those assumptions.

// File: rtl/ddr2_seq_pkg.sv
package ddr2_seq_pkg;

    // run state of the step engine
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CMD  = 2'd1,
        SQ_WAIT = 2'd2
    } sq_state_e;

    // width of the slot index field in the issue register
    localparam int IDX_W   = 4;
    // register word address width: two select bits above the slot index
    localparam int RADDR_W = IDX_W + 2;
    // address bus width formed from two table bytes
    localparam int A_W     = 16;

    // field positions inside the command word
    localparam int CKE_BIT = 12;
    localparam int CTL_LSB = 8;   // bits 11:8 = WE#, CAS#, RAS#, CS#
    localparam int ALO_LSB = 24;  // A[7:0]

    // field positions inside the timing word
    localparam int AHI_LSB  = 0;  // A[15:8]
    localparam int BA_LSB   = 8;
    localparam int WAIT_LSB = 11;

    // issue register
    localparam int GO_BIT = 4;

    // register select codes in reg_addr[RADDR_W-1 -: 2]
    localparam logic [1:0] SEL_CMD = 2'd0;
    localparam logic [1:0] SEL_TIM = 2'd1;
    localparam logic [1:0] SEL_CTL = 2'd2;

    // control slots under SEL_CTL
    localparam logic [IDX_W-1:0] CTL_ISSUE = 4'd0;
    localparam logic [IDX_W-1:0] CTL_START = 4'd1;

endpackage

// File: rtl/ddr2_seq_regs.sv
module ddr2_seq_regs
    import ddr2_seq_pkg::*;
#(
    parameter int DEPTH  = 12,
    parameter int BA_W   = 2,
    parameter int WAIT_W = 21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [RADDR_W-1:0]   reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 busy,
    input  logic [IDX_W-1:0]     last_idx,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 issue_we,
    output logic                 ent_cke,
    output logic [3:0]           ent_ctl,
    output logic [A_W-1:0]       ent_a,
    output logic [BA_W-1:0]      ent_ba,
    output logic [WAIT_W-1:0]    ent_wait,
    output logic                 release_o
);

    localparam logic [IDX_W-1:0] LAST_ENT = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][31:0] cmd;
        logic [DEPTH-1:0][31:0] tim;
        logic [1:0]             start;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [1:0]        sel;
    logic [IDX_W-1:0]  ent;
    logic              ent_ok;
    logic [31:0]       cur_cmd;
    logic [31:0]       cur_tim;

    assign sel    = reg_addr[RADDR_W-1 -: 2];
    assign ent    = reg_addr[IDX_W-1:0];
    assign ent_ok = (ent <= LAST_ENT);

    assign issue_we = reg_we && (sel == SEL_CTL) && (ent == CTL_ISSUE);

    // next-state: table writes blocked while a run is active
    always_comb begin
        regs_d = regs_q;
        if (reg_we) begin
            unique case (sel)
                SEL_CMD: if (!busy && ent_ok) regs_d.cmd[ent] = reg_wdata;
                SEL_TIM: if (!busy && ent_ok) regs_d.tim[ent] = reg_wdata;
                SEL_CTL: if (ent == CTL_START) regs_d.start = reg_wdata[1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_CMD: if (ent_ok) reg_rdata = regs_q.cmd[ent];
            SEL_TIM: if (ent_ok) reg_rdata = regs_q.tim[ent];
            SEL_CTL: begin
                if (ent == CTL_ISSUE) begin
                    reg_rdata[IDX_W-1:0] = last_idx;
                    reg_rdata[GO_BIT]    = busy;
                end else if (ent == CTL_START) begin
                    reg_rdata[1:0] = regs_q.start;
                end
            end
            default: ;
        endcase
    end

    // field extraction for the slot under execution
    assign cur_cmd  = regs_q.cmd[rd_idx];
    assign cur_tim  = regs_q.tim[rd_idx];
    assign ent_cke  = cur_cmd[CKE_BIT];
    assign ent_ctl  = cur_cmd[CTL_LSB +: 4];
    assign ent_a    = {cur_tim[AHI_LSB +: 8], cur_cmd[ALO_LSB +: 8]};
    assign ent_ba   = cur_tim[BA_LSB +: BA_W];
    assign ent_wait = cur_tim[WAIT_LSB +: WAIT_W];

    assign release_o = &regs_q.start;

endmodule

// File: rtl/ddr2_seq_engine.sv
module ddr2_seq_engine
    import ddr2_seq_pkg::*;
#(
    parameter int DEPTH  = 12,
    parameter int WAIT_W = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_we,
    input  logic               issue_go,
    input  logic [IDX_W-1:0]   issue_last,
    input  logic               ent_cke,
    input  logic [WAIT_W-1:0]  ent_wait,
    output logic               busy,
    output logic               cmd_phase,
    output logic [IDX_W-1:0]   cur_idx,
    output logic [IDX_W-1:0]   last_idx,
    output logic               cke_hold
);

    localparam logic [IDX_W-1:0] LAST_ENT = IDX_W'(DEPTH - 1);

    typedef struct packed {
        sq_state_e          st;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   last;
        logic [WAIT_W-1:0]  cnt;
        logic               cke;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        unique case (eng_q.st)
            SQ_IDLE: begin
                // out-of-range index drops the whole write
                if (issue_we && (issue_last <= LAST_ENT)) begin
                    eng_d.last = issue_last;
                    if (issue_go) begin
                        eng_d.idx = '0;
                        eng_d.st  = SQ_CMD;
                    end
                end
            end
            SQ_CMD: begin
                // one command cycle, then W+1 NOP cycles
                eng_d.cke = ent_cke;
                eng_d.cnt = ent_wait;
                eng_d.st  = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (eng_q.cnt == '0) begin
                    if (eng_q.idx == eng_q.last) begin
                        eng_d.st = SQ_IDLE;
                    end else begin
                        eng_d.idx = eng_q.idx + 1'b1;
                        eng_d.st  = SQ_CMD;
                    end
                end else begin
                    eng_d.cnt = eng_q.cnt - 1'b1;
                end
            end
            default: eng_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign busy      = (eng_q.st != SQ_IDLE);
    assign cmd_phase = (eng_q.st == SQ_CMD);
    assign cur_idx   = eng_q.idx;
    assign last_idx  = eng_q.last;
    assign cke_hold  = eng_q.cke;

endmodule

// File: rtl/ddr2_seq_pins.sv
module ddr2_seq_pins
    import ddr2_seq_pkg::*;
#(
    parameter int BA_W = 2
) (
    input  logic             cmd_phase,
    input  logic             cke_hold,
    input  logic             ent_cke,
    input  logic [3:0]       ent_ctl,
    input  logic [A_W-1:0]   ent_a,
    input  logic [BA_W-1:0]  ent_ba,
    output logic             ddr_cke,
    output logic             ddr_cs_n,
    output logic             ddr_ras_n,
    output logic             ddr_cas_n,
    output logic             ddr_we_n,
    output logic [BA_W-1:0]  ddr_ba,
    output logic [A_W-1:0]   ddr_a
);

    // pins follow the registered engine state; outside a command
    // cycle everything is deselected and CKE keeps its held level
    always_comb begin
        ddr_cke   = cke_hold;
        ddr_cs_n  = 1'b1;
        ddr_ras_n = 1'b1;
        ddr_cas_n = 1'b1;
        ddr_we_n  = 1'b1;
        ddr_ba    = '0;
        ddr_a     = '0;
        if (cmd_phase) begin
            ddr_cke   = ent_cke;
            ddr_cs_n  = ent_ctl[0];
            ddr_ras_n = ent_ctl[1];
            ddr_cas_n = ent_ctl[2];
            ddr_we_n  = ent_ctl[3];
            ddr_ba    = ent_ba;
            ddr_a     = ent_a;
        end
    end

endmodule

// File: rtl/ddr2_init_sequencer.sv
module ddr2_init_sequencer
    import ddr2_seq_pkg::*;
#(
    parameter int DEPTH  = 12,   // table slots, at most 16
    parameter int BA_W   = 2,    // bank bits, at most 3
    parameter int WAIT_W = 21    // wait-count bits, at most 21
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [5:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                ddr_cke,
    output logic                ddr_cs_n,
    output logic                ddr_ras_n,
    output logic                ddr_cas_n,
    output logic                ddr_we_n,
    output logic [BA_W-1:0]     ddr_ba,
    output logic [15:0]         ddr_a,
    output logic                ctrl_release
);

    logic               issue_we;
    logic               issue_go;
    logic [IDX_W-1:0]   issue_last;
    logic               eng_busy;
    logic               eng_cmd_phase;
    logic [IDX_W-1:0]   eng_idx;
    logic [IDX_W-1:0]   eng_last;
    logic               eng_cke;
    logic               ent_cke;
    logic [3:0]         ent_ctl;
    logic [A_W-1:0]     ent_a;
    logic [BA_W-1:0]    ent_ba;
    logic [WAIT_W-1:0]  ent_wait;

    assign issue_go   = reg_wdata[GO_BIT];
    assign issue_last = reg_wdata[IDX_W-1:0];

    ddr2_seq_regs #(
        .DEPTH  (DEPTH),
        .BA_W   (BA_W),
        .WAIT_W (WAIT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (eng_busy),
        .last_idx  (eng_last),
        .rd_idx    (eng_idx),
        .issue_we  (issue_we),
        .ent_cke   (ent_cke),
        .ent_ctl   (ent_ctl),
        .ent_a     (ent_a),
        .ent_ba    (ent_ba),
        .ent_wait  (ent_wait),
        .release_o (ctrl_release)
    );

    ddr2_seq_engine #(
        .DEPTH  (DEPTH),
        .WAIT_W (WAIT_W)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_we   (issue_we),
        .issue_go   (issue_go),
        .issue_last (issue_last),
        .ent_cke    (ent_cke),
        .ent_wait   (ent_wait),
        .busy       (eng_busy),
        .cmd_phase  (eng_cmd_phase),
        .cur_idx    (eng_idx),
        .last_idx   (eng_last),
        .cke_hold   (eng_cke)
    );

    ddr2_seq_pins #(
        .BA_W (BA_W)
    ) u_pins (
        .cmd_phase (eng_cmd_phase),
        .cke_hold  (eng_cke),
        .ent_cke   (ent_cke),
        .ent_ctl   (ent_ctl),
        .ent_a     (ent_a),
        .ent_ba    (ent_ba),
        .ddr_cke   (ddr_cke),
        .ddr_cs_n  (ddr_cs_n),
        .ddr_ras_n (ddr_ras_n),
        .ddr_cas_n (ddr_cas_n),
        .ddr_we_n  (ddr_we_n),
        .ddr_ba    (ddr_ba),
        .ddr_a     (ddr_a)
    );

endmodule

// File: rtl/ddr2_seq_checker.sv
module ddr2_seq_checker #(
    parameter int BA_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             cmd_phase,
    input logic [3:0]       cur_idx,
    input logic [3:0]       last_idx,
    input logic             issue_we,
    input logic             issue_go,
    input logic             ddr_cke,
    input logic             ddr_cs_n,
    input logic             ddr_ras_n,
    input logic             ddr_cas_n,
    input logic             ddr_we_n,
    input logic [BA_W-1:0]  ddr_ba,
    input logic [15:0]      ddr_a
);

    a_r4_wait_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_phase |-> (ddr_cs_n && ddr_ras_n && ddr_cas_n && ddr_we_n));

    a_r4_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_phase |-> (ddr_a == '0 && ddr_ba == '0));

    a_r10_cke_held: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_phase |-> $stable(ddr_cke));

    a_r5_start_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(issue_we && issue_go));

    a_r2_first_is_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cmd_phase && cur_idx == 4'd0));

    a_r2_idx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cur_idx <= last_idx));

    a_r6_last_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(last_idx));

endmodule

bind ddr2_init_sequencer ddr2_seq_checker #(.BA_W(BA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (eng_busy),
    .cmd_phase (eng_cmd_phase),
    .cur_idx   (eng_idx),
    .last_idx  (eng_last),
    .issue_we  (issue_we),
    .issue_go  (issue_go),
    .ddr_cke   (ddr_cke),
    .ddr_cs_n  (ddr_cs_n),
    .ddr_ras_n (ddr_ras_n),
    .ddr_cas_n (ddr_cas_n),
    .ddr_we_n  (ddr_we_n),
    .ddr_ba    (ddr_ba),
    .ddr_a     (ddr_a)
);

// File: tb/ddr2_init_sequencer_bench.sv
`timescale 1ns/1ps
module ddr2_init_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
    logic [1:0]  ddr_ba;
    logic [15:0] ddr_a;
    logic        ctrl_release;

    always #5 clk = ~clk;

    ddr2_init_sequencer u_ddr2_init_sequencer (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ddr_cke(ddr_cke),
        .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n),
        .ddr_we_n(ddr_we_n), .ddr_ba(ddr_ba), .ddr_a(ddr_a),
        .ctrl_release(ctrl_release)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [31:0] m_cmd [12];
    logic [31:0] m_tim [12];
    logic [3:0]  m_last;
    logic [1:0]  m_start;
    logic        m_cke;
    logic [22:0] eq [$];
    bit          was_busy;

    function automatic logic [22:0] nop_of(input logic cke);
        return {cke, 4'hF, 2'b00, 16'h0000};
    endfunction

    task automatic build_run();
        for (int e = 0; e <= int'(m_last); e++) begin
            logic [31:0] c;
            logic [31:0] t;
            int w;
            c = m_cmd[e];
            t = m_tim[e];
            w = int'(t[31:11]);
            eq.push_back({c[12], c[8], c[9], c[10], c[11], t[9:8], t[7:0], c[31:24]});
            for (int k = 0; k <= w; k++) eq.push_back(nop_of(c[12]));
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            eq.delete();
            m_cke = 1'b0; m_last = 4'd0; m_start = 2'd0;
            for (int i = 0; i < 12; i++) begin m_cmd[i] = '0; m_tim[i] = '0; end
        end else begin
            was_busy = (eq.size() != 0);
            if (was_busy) begin
                m_cke = eq[0][22];
                void'(eq.pop_front());
            end
            if (reg_we) begin
                if (reg_addr[5:4] == 2'd0 && !was_busy && reg_addr[3:0] < 4'd12)
                    m_cmd[reg_addr[3:0]] = reg_wdata;
                if (reg_addr[5:4] == 2'd1 && !was_busy && reg_addr[3:0] < 4'd12)
                    m_tim[reg_addr[3:0]] = reg_wdata;
                if (reg_addr == 6'h21) m_start = reg_wdata[1:0];
                if (reg_addr == 6'h20 && !was_busy && reg_wdata[3:0] < 4'd12) begin
                    m_last = reg_wdata[3:0];
                    if (reg_wdata[4]) build_run();
                end
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [5:0] a);
        logic [31:0] r;
        r = '0;
        if (a[5:4] == 2'd0 && a[3:0] < 4'd12) r = m_cmd[a[3:0]];
        if (a[5:4] == 2'd1 && a[3:0] < 4'd12) r = m_tim[a[3:0]];
        if (a == 6'h20) r = {27'd0, (eq.size() != 0), m_last};
        if (a == 6'h21) r = {30'd0, m_start};
        return r;
    endfunction

    function automatic logic [31:0] act_pins();
        return {9'd0, ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, ddr_ba, ddr_a};
    endfunction

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk("R3/R4/R10 pins vs model", act_pins(),
                {9'd0, (eq.size() != 0) ? eq[0] : nop_of(m_cke)});
            chk("R2/R8 readback vs model", reg_rdata, exp_rd(reg_addr));
            chk("R9 release vs model", {31'd0, ctrl_release}, {31'd0, m_start == 2'd3});
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_at(input logic [5:0] a);
        @(negedge clk);
        reg_addr = a;
        #2;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        @(negedge clk);
        reg_addr = 6'h20;
        #2;
        while (reg_rdata[4] && n < 5000) begin
            n++;
            @(negedge clk);
            #2;
        end
    endtask

    logic [31:0] std_cmd [12];
    logic [31:0] std_tim [12];
    int n_busy;

    initial begin
        std_cmd[0]  = 32'h00FFFFFF; std_tim[0]  = (32'd158 << 11);
        std_cmd[1]  = 32'h00FFF401; std_tim[1]  = 32'h04 | (32'd4 << 11);
        std_cmd[2]  = 32'h00FFF001; std_tim[2]  = 32'h200;
        std_cmd[3]  = 32'h00FFF001; std_tim[3]  = 32'h300;
        std_cmd[4]  = 32'h40FFF001; std_tim[4]  = 32'h100;
        std_cmd[5]  = 32'h52FFF001; std_tim[5]  = 32'h0B;
        std_cmd[6]  = 32'h00FFF401; std_tim[6]  = 32'h04 | (32'd4 << 11);
        std_cmd[7]  = 32'h00FFF801; std_tim[7]  = (32'd49 << 11);
        std_cmd[8]  = 32'h00FFF801; std_tim[8]  = (32'd49 << 11);
        std_cmd[9]  = 32'h53FFF001; std_tim[9]  = 32'h0A;
        std_cmd[10] = 32'hC0FFF001; std_tim[10] = 32'h103;
        std_cmd[11] = 32'h40FFF001; std_tim[11] = 32'h100 | (32'd138 << 11);

        rst_n = 1'b0; reg_we = 1'b0; reg_addr = 6'h20; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1 reset pins", act_pins(), {9'd0, 1'b0, 4'hF, 18'd0});
        chk("R1 reset issue reg", reg_rdata, 32'd0);
        chk("R1 reset release", {31'd0, ctrl_release}, 32'd0);

        // standard power-up run, undisturbed
        for (int e = 0; e < 12; e++) begin
            wr(6'(e), std_cmd[e]);
            wr(6'(16 + e), std_tim[e]);
        end
        wr(6'h20, 32'h1B);
        #2;
        chk("R2 busy with last index", reg_rdata, 32'h1B);
        n_busy = 0;
        while (reg_rdata[4] && n_busy < 5000) begin
            n_busy++;
            @(negedge clk);
            #2;
        end
        chk("R5 run length sum(W+2)", n_busy, 32'd426);
        chk("R10 CKE held high after run", {31'd0, ddr_cke}, 32'd1);

        // second run with writes attempted while busy
        wr(6'h20, 32'h1B);
        repeat (5) @(negedge clk);
        wr(6'h05, 32'hDEADBEEF);
        wr(6'h15, 32'h0);
        wr(6'h20, 32'h12);
        wait_idle(n_busy);
        repeat (3) @(negedge clk);
        #2;
        chk("R6 no restart after busy-time issue", reg_rdata, 32'h0B);
        rd_at(6'h05);
        chk("R6 command word kept", reg_rdata, 32'h52FFF001);
        rd_at(6'h15);
        chk("R6 timing word kept", reg_rdata, 32'h0B);

        // issue register corner cases
        wr(6'h20, 32'h05);
        rd_at(6'h20);
        chk("R7 index-only write", reg_rdata, 32'h05);
        wr(6'h20, 32'h1C);
        rd_at(6'h20);
        chk("R7 out-of-range index ignored", reg_rdata, 32'h05);

        // table addressing
        wr(6'h0C, 32'h12345678);
        rd_at(6'h0C);
        chk("R8 slot 12 dropped", reg_rdata, 32'd0);
        rd_at(6'h13);
        chk("R8 timing word of slot 3", reg_rdata, 32'h300);

        // start register
        wr(6'h21, 32'h1);
        #2;
        chk("R9 release low at 1", {31'd0, ctrl_release}, 32'd0);
        rd_at(6'h21);
        chk("R9 start readback", reg_rdata, 32'h1);
        wr(6'h21, 32'h3);
        #2;
        chk("R9 release high at 3", {31'd0, ctrl_release}, 32'd1);

        // short run ending with CKE low
        wr(6'h00, 32'h52FFF001); wr(6'h10, 32'h0B | (32'd1 << 11));
        wr(6'h01, 32'h00FFF401); wr(6'h11, 32'h04 | (32'd2 << 11));
        wr(6'h02, 32'h00FFEFFE); wr(6'h12, 32'h0);
        @(negedge clk);
        reg_addr = 6'h20;
        wr(6'h20, 32'h12);
        #2;
        chk("R3 mode-register command cycle", act_pins(),
            {9'd0, 1'b1, 4'b0000, 2'b00, 16'h0B52});
        chk("R2 busy short run", reg_rdata, 32'h12);
        @(negedge clk); #2;
        chk("R4 first NOP", act_pins(), {9'd0, 1'b1, 4'hF, 18'd0});
        @(negedge clk); #2;
        chk("R4 second NOP", act_pins(), {9'd0, 1'b1, 4'hF, 18'd0});
        @(negedge clk); #2;
        chk("R4 next command after W+1 NOPs", act_pins(),
            {9'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 16'h0400});
        wait_idle(n_busy);
        repeat (3) @(negedge clk);
        #2;
        chk("R10 CKE held low when idle", act_pins(), {9'd0, 1'b0, 4'hF, 18'd0});

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule